// File: doc/BRIEF.md
# Branch and Program Counter Unit

This block keeps the program counter of a very small processor whose program store holds 64 words, and it chooses the next fetch address on every clock. When no branch instruction is present, the counter steps forward by one. When a branch is presented, its two type bits select one of four behaviours. An unconditional jump and two conditional jumps take their destination from an absolute address field in the instruction. A fourth, indexed jump builds the destination from two general registers, which lets software return from subroutines and dispatch through jump tables.

The conditional forms read two flags that the arithmetic unit produced earlier. One jump is taken when the zero flag is clear. The other is taken when the carry (borrow) flag reports that the last unsigned compare found its first operand smaller. A combinational taken indicator reports, in the same cycle as the branch request, whether the branch will redirect fetch. The new address appears on the counter output after the next rising clock edge.

Top module: `branch_pc_unit`

## Requirements
- R1: While the synchronous reset `rst` is high, `taken` is 0, and the edge on which reset is sampled high sets `pc` to 0.
- R2: When `br_valid` is 0, `taken` is 0 and `pc` becomes `pc + 1` at the next edge, whatever `br_kind`, `br_addr` and the flags hold.
- R3: The counter is 6 bits wide, and stepping forward from 63 gives 0.
- R4: With `br_valid` = 1 and `br_kind` = 2'b00 (unconditional), `taken` is 1 and `pc` becomes `br_addr` at the next edge.
- R5: With `br_valid` = 1 and `br_kind` = 2'b01 (not zero), `taken` equals the inverse of `flag_z`. When the branch is taken, `pc` becomes `br_addr`.
- R6: With `br_valid` = 1 and `br_kind` = 2'b10 (less), `taken` equals `flag_c`. When the branch is taken, `pc` becomes `br_addr`.
- R7: With `br_valid` = 1 and `br_kind` = 2'b11 (indexed), `taken` is 1 and `pc` becomes {`idx_hi`, `idx_lo`}: `idx_lo` supplies bits 3:0 and `idx_hi` supplies bits 5:4. `br_addr` is not used.
- R8: A conditional branch that is not taken leaves `taken` at 0, and `pc` becomes `pc + 1` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_valid | input | 1 | A branch instruction is present this cycle |
| br_kind | input | 2 | Branch type: 00 always, 01 not zero, 10 less, 11 indexed |
| br_addr | input | 6 | Absolute destination from the instruction |
| idx_lo | input | 4 | Register value that supplies the low bits of an indexed destination |
| idx_hi | input | 2 | Register bits that supply the high bits of an indexed destination |
| flag_z | input | 1 | Zero flag from the last ALU operation |
| flag_c | input | 1 | Carry/borrow flag; 1 means the last compare found "less" |
| pc | output | 6 | Current program counter |
| taken | output | 1 | The branch presented this cycle redirects fetch |

## Verification
The bench targets the wrap from 63 to 0. A counter that is one bit too wide, or that saturates, would fetch from a nonexistent address 64 or stall at 63. Each conditional type is driven with both flag values, so a design that inverts a condition or checks the wrong flag shows up as a wrong `taken` and a wrong `pc`. Indexed jumps use register values that differ from `br_addr`, which catches a swapped nibble order or a design that takes the instruction field instead of the registers. Branch fields held while `br_valid` is low, and branch requests made during reset, confirm that neither can move the counter.

// File: rtl/branch_pc_unit.sv
module branch_pc_unit #(
  parameter int ADDR_W = 6,
  parameter int REG_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     br_valid,
  input  logic [1:0]               br_kind,
  input  logic [ADDR_W-1:0]        br_addr,
  input  logic [REG_W-1:0]         idx_lo,
  input  logic [ADDR_W-REG_W-1:0]  idx_hi,
  input  logic                     flag_z,
  input  logic                     flag_c,
  output logic [ADDR_W-1:0]        pc,
  output logic                     taken
);

  typedef enum logic [1:0] {
    BK_ALWAYS  = 2'b00,
    BK_NONZERO = 2'b01,
    BK_BELOW   = 2'b10,
    BK_INDEX   = 2'b11
  } br_kind_e;

  br_kind_e          kind;
  logic              cond_ok;
  logic [ADDR_W-1:0] idx_addr;
  logic [ADDR_W-1:0] dest;
  logic [ADDR_W-1:0] pc_next;

  assign kind     = br_kind_e'(br_kind);
  assign idx_addr = {idx_hi, idx_lo};

  always_comb begin
    case (kind)
      BK_ALWAYS:  cond_ok = 1'b1;
      BK_NONZERO: cond_ok = ~flag_z;
      BK_BELOW:   cond_ok = flag_c;
      default:    cond_ok = 1'b1;
    endcase
  end

  assign dest    = (kind == BK_INDEX) ? idx_addr : br_addr;
  assign taken   = ~rst & br_valid & cond_ok;
  assign pc_next = taken ? dest : pc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    !br_valid |=> pc == ADDR_W'($past(pc) + 1)); // R2

  AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    !br_valid |-> !taken); // R2

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b00) |-> taken); // R4

  AST_NONZERO_COND: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b01) |-> (taken == !flag_z)); // R5

  AST_BELOW_COND: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b10) |-> (taken == flag_c)); // R6

  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (taken && br_kind != 2'b11) |=> pc == $past(br_addr)); // R4

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_kind == 2'b11) |=> pc == {$past(idx_hi), $past(idx_lo)}); // R7

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !taken) |=> pc == ADDR_W'($past(pc) + 1)); // R8

endmodule

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       br_valid;
  logic [1:0] br_kind;
  logic [5:0] br_addr;
  logic [3:0] idx_lo;
  logic [1:0] idx_hi;
  logic       flag_z;
  logic       flag_c;
  logic [5:0] pc;
  logic       taken;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  logic [5:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pc_unit u_dut (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_kind(br_kind),
    .br_addr(br_addr), .idx_lo(idx_lo), .idx_hi(idx_hi),
    .flag_z(flag_z), .flag_c(flag_c), .pc(pc), .taken(taken)
  );

  function automatic bit model_taken(bit v, logic [1:0] k, bit z, bit c);
    if (!v) return 0;
    case (k)
      2'b00: return 1;
      2'b01: return !z;
      2'b10: return c;
      default: return 1;
    endcase
  endfunction

  function automatic logic [5:0] model_next(logic [5:0] cur, bit v, logic [1:0] k,
      logic [5:0] a, logic [3:0] lo, logic [1:0] hi, bit z, bit c);
    if (model_taken(v, k, z, c)) return (k == 2'b11) ? {hi, lo} : a;
    return cur + 6'd1;
  endfunction

  function automatic string req_of(bit v, logic [1:0] k, bit tk);
    if (!v) return "R2";
    if (!tk) return "R8";
    case (k)
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] k, logic [5:0] a, logic [3:0] lo,
                      logic [1:0] hi, bit z, bit c, string req_override = "");
    bit et;
    string req;
    br_valid = v; br_kind = k; br_addr = a; idx_lo = lo; idx_hi = hi;
    flag_z = z; flag_c = c;
    #1;
    et  = model_taken(v, k, z, c);
    req = (req_override != "") ? req_override : req_of(v, k, et);
    check(req, "taken", int'(taken), int'(et));
    exp_pc = model_next(exp_pc, v, k, a, lo, hi, z, c);
    @(negedge clk);
    check(req, "pc", int'(pc), int'(exp_pc));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5924));
    rst = 1'b1; br_valid = 1'b1; br_kind = 2'b00; br_addr = 6'd40;
    idx_lo = 4'd0; idx_hi = 2'd0; flag_z = 1'b0; flag_c = 1'b0;
    @(negedge clk);
    #1;
    check("R1", "taken in reset", int'(taken), 0);
    @(negedge clk);
    check("R1", "pc after reset", int'(pc), 0);
    exp_pc = 6'd0;
    rst = 1'b0;

    // R2: idle with busy branch fields
    step(0, 2'b00, 6'd17, 4'd9, 2'd3, 0, 1);
    step(0, 2'b11, 6'd50, 4'd2, 2'd1, 1, 0);
    // R4 unconditional
    step(1, 2'b00, 6'd60, 4'd1, 2'd2, 1, 0);
    // R3 wrap 60..63 -> 0
    for (int i = 0; i < 4; i++) step(0, 2'b01, 6'd5, 4'd5, 2'd0, 0, 0, "R3");
    check("R3", "wrapped pc", int'(pc), 0);
    // R5 both flag values
    step(1, 2'b01, 6'd33, 4'd7, 2'd1, 0, 0);
    step(1, 2'b01, 6'd12, 4'd7, 2'd1, 1, 1);
    // R6 both flag values
    step(1, 2'b10, 6'd21, 4'd3, 2'd2, 1, 1);
    step(1, 2'b10, 6'd44, 4'd3, 2'd2, 0, 0);
    // R7 indexed: nibble order, instruction field ignored
    step(1, 2'b11, 6'd0, 4'hA, 2'd2, 0, 0);
    check("R7", "index order", int'(pc), 42);
    step(1, 2'b11, 6'd63, 4'hF, 2'd3, 1, 0);
    step(1, 2'b11, 6'd63, 4'h0, 2'd0, 1, 1);
    // R1 reset mid-run with branch requested
    rst = 1'b1; br_valid = 1'b1; br_kind = 2'b00; br_addr = 6'd9;
    #1;
    check("R1", "taken in reset", int'(taken), 0);
    @(negedge clk);
    check("R1", "pc after reset", int'(pc), 0);
    exp_pc = 6'd0;
    rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) != 0, 2'($urandom), 6'($urandom), 4'($urandom),
           2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule